// File: doc/BRIEF.md
# PWM Leg Pulse-Deletion and Underlap Stage

This block conditions the switching signal for one leg of a three-phase inverter bridge. It first filters the raw PWM bit so that no high or low run shorter than a programmed minimum reaches the switches. It then splits the filtered level into a complementary high-side/low-side drive pair. Each turn-on edge is held back by a programmed underlap so that both switches are off for that interval. Last, an inhibit bit and a trip input force both drives low without stopping the internal sequencing. All times are counted in ticks of a prescaler that fires once every N clocks, where N = 2^`div_sel`.

The filter is a two-state machine. In `FLT_STEADY` the sampled input matches the accepted level. When the input differs on a tick, the machine moves to `FLT_QUALIFY`. It returns to `FLT_STEADY` either by acceptance, when the new level has been held for the deletion count, or by rejection, when the input falls back first. The underlap machine has four states. `LEG_LOW_ON` and `LEG_HIGH_ON` each drive one switch. `LEG_GAP_UP` and `LEG_GAP_DN` leave both switches off while the underlap counts. The on-states move to the gap that heads for the other level when the filtered level flips. A gap completes into its on-state after T ticks, or reverses into the opposite gap if the filtered level flips back first. Reset enters `LEG_GAP_DN`.

Top module: `pwm_leg_cond`

## Requirements
- R1: A level of either polarity that the tick samples see for at least D consecutive ticks is passed on with its length unchanged. A shorter run is removed, and the filtered line keeps its previous level for that interval.
- R2: D = 128 − `del_sel`, so a `del_sel` of 0 gives 128 ticks and 127 gives 1 tick.
- R3: A tick occurs once every N = 2^`div_sel` clocks, with `div_sel` values above 5 treated as 5 (N = 32). The first tick falls on the Nth rising clock edge after reset is released.
- R4: T = 64 − `dly_sel`, so a `dly_sel` of 0 gives 64 ticks and 63 gives 1 tick.
- R5: Suppose a new level is first sampled at a tick and accepted on its Dth sampled tick. The drive that was on goes low on the next tick after acceptance. The drive for the new level goes high T ticks after that. Both are low in between.
- R6: `drv_top` and `drv_bot` are never high together. `drv_top` only turns on after a filtered high and `drv_bot` only after a filtered low.
- R7: A raw pulse of exactly D ticks, with D > T, gives a drive pulse of D − T ticks.
- R8: `inhibit` high forces both drives low in the same cycle while both machines keep running. On release, the drive chosen by the current state reappears in the same cycle.
- R9: `trip` high forces both drives low in the same cycle. Release restores the drive chosen by the current state.
- R10: While `rst_n` is low both drives are low. After release, `drv_bot` goes high at the Tth tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_raw | input | 1 | Unconditioned PWM level for this leg |
| del_sel | input | 7 | Deletion select, count = 128 − value |
| dly_sel | input | 6 | Underlap select, count = 64 − value |
| div_sel | input | 3 | Tick divider exponent, N = 2^value, capped at 32 |
| inhibit | input | 1 | High forces both drives low |
| trip | input | 1 | High forces both drives low |
| drv_top | output | 1 | High-side switch drive |
| drv_bot | output | 1 | Low-side switch drive |

## Verification
The bench aims at the deletion threshold from both sides: a run of exactly D ticks must pass and one of D − 1 must vanish. A design with an off-by-one compare would instead lose the boundary pulse or let a short glitch through. It also feeds a high pulse of exactly D ticks and measures the D − T drive pulse. A design that delays both edges, or delays the falling edge instead of the rising one, would show a wrong width there. The extreme select codes (0 and all-ones) and a divider code above the cap are checked. A wrong inverse coding or a missing clamp would shift every event time. Inhibit and trip are released after the filtered level has changed underneath them. A design that froze its sequencing while gated would bring back the stale drive.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic {
        FLT_STEADY,
        FLT_QUALIFY
    } flt_state_t;

    typedef enum logic [1:0] {
        LEG_LOW_ON,
        LEG_GAP_UP,
        LEG_HIGH_ON,
        LEG_GAP_DN
    } leg_state_t;

endpackage

// File: rtl/plc_tick_gen.sv
module plc_tick_gen #(
    parameter int DIV_W   = 3,
    parameter int LOG_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CW = (LOG_MAX < 1) ? 1 : LOG_MAX;

    logic [DIV_W-1:0] shift_amt;
    logic [CW-1:0]    limit;
    logic [CW-1:0]    pcnt;

    always_comb begin
        shift_amt = (div_sel > DIV_W'(LOG_MAX)) ? DIV_W'(LOG_MAX) : div_sel;
        limit     = CW'((32'd1 << shift_amt) - 32'd1);
    end

    assign tick = (pcnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + CW'(1);
    end

    // R3: with a divider above one, two ticks never fall on adjacent clocks
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0) |=> !tick);

endmodule

// File: rtl/plc_run_filter.sv
module plc_run_filter
    import plc_pkg::*;
#(
    parameter int DEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw,
    input  logic [DEL_W-1:0] del_sel,
    output logic             filt
);
    localparam int CW = DEL_W + 1;

    flt_state_t    st, st_n;
    logic [CW-1:0] need;
    logic [CW-1:0] run, run_n;
    logic          filt_n;

    assign need = {1'b1, {DEL_W{1'b0}}} - {1'b0, del_sel};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= FLT_STEADY;
            run  <= '0;
            filt <= 1'b0;
        end else begin
            st   <= st_n;
            run  <= run_n;
            filt <= filt_n;
        end
    end

    always_comb begin
        st_n   = st;
        run_n  = run;
        filt_n = filt;
        if (tick) begin
            unique case (st)
                FLT_STEADY: begin
                    if (raw != filt) begin
                        if (need == CW'(1)) begin
                            filt_n = raw;
                        end else begin
                            st_n  = FLT_QUALIFY;
                            run_n = CW'(1);
                        end
                    end
                end
                FLT_QUALIFY: begin
                    if (raw == filt) begin
                        st_n  = FLT_STEADY;
                        run_n = '0;
                    end else if ((run + CW'(1)) >= need) begin
                        filt_n = raw;
                        st_n   = FLT_STEADY;
                        run_n  = '0;
                    end else begin
                        run_n = run + CW'(1);
                    end
                end
            endcase
        end
    end

    // R3: the accepted level only moves on a tick
    a_r3_filter_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(filt));

    // R1: a change of the accepted level always copies the sampled input
    a_r1_filter_takes_input: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> (filt == $past(raw)));

endmodule

// File: rtl/plc_underlap_fsm.sv
module plc_underlap_fsm
    import plc_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             filt,
    input  logic [DLY_W-1:0] dly_sel,
    output logic             drive_hi,
    output logic             drive_lo
);
    localparam int CW = DLY_W + 1;

    leg_state_t    st, st_n;
    logic [CW-1:0] gap_len;
    logic [CW-1:0] cnt, cnt_n;

    assign gap_len = {1'b1, {DLY_W{1'b0}}} - {1'b0, dly_sel};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= LEG_GAP_DN;
            cnt <= CW'(1);
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (tick) begin
            unique case (st)
                LEG_LOW_ON: begin
                    if (filt) begin
                        st_n  = LEG_GAP_UP;
                        cnt_n = CW'(1);
                    end
                end
                LEG_HIGH_ON: begin
                    if (!filt) begin
                        st_n  = LEG_GAP_DN;
                        cnt_n = CW'(1);
                    end
                end
                LEG_GAP_UP: begin
                    if (!filt) begin
                        st_n  = LEG_GAP_DN;
                        cnt_n = CW'(1);
                    end else if (cnt >= gap_len) begin
                        st_n = LEG_HIGH_ON;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
                LEG_GAP_DN: begin
                    if (filt) begin
                        st_n  = LEG_GAP_UP;
                        cnt_n = CW'(1);
                    end else if (cnt >= gap_len) begin
                        st_n = LEG_LOW_ON;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        drive_hi = (st == LEG_HIGH_ON);
        drive_lo = (st == LEG_LOW_ON);
    end

    // R6: high side only turns on after a filtered high
    a_r6_hi_after_filt_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_hi) |-> $past(filt));

    // R6: low side only turns on after a filtered low
    a_r6_lo_after_filt_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_lo) |-> !$past(filt));

    // R5: a side never turns on in the cycle the other side turns off
    a_r5_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_hi) |-> !$past(drive_lo));

endmodule

// File: rtl/pwm_leg_cond.sv
module pwm_leg_cond #(
    parameter int DEL_W       = 7,
    parameter int DLY_W       = 6,
    parameter int DIV_W       = 3,
    parameter int DIV_LOG_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_raw,
    input  logic [DEL_W-1:0] del_sel,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             inhibit,
    input  logic             trip,
    output logic             drv_top,
    output logic             drv_bot
);
    logic tick;
    logic filt;
    logic drive_hi;
    logic drive_lo;
    logic gate_open;

    plc_tick_gen #(
        .DIV_W  (DIV_W),
        .LOG_MAX(DIV_LOG_MAX)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_sel(div_sel),
        .tick   (tick)
    );

    plc_run_filter #(
        .DEL_W(DEL_W)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .raw    (pwm_raw),
        .del_sel(del_sel),
        .filt   (filt)
    );

    plc_underlap_fsm #(
        .DLY_W(DLY_W)
    ) u_leg (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .filt    (filt),
        .dly_sel (dly_sel),
        .drive_hi(drive_hi),
        .drive_lo(drive_lo)
    );

    assign gate_open = !inhibit && !trip;
    assign drv_top   = drive_hi && gate_open;
    assign drv_bot   = drive_lo && gate_open;

    // R1: the filtered level never moves while the raw input agrees with it
    a_r1_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwm_raw) == $past(filt)) |-> $stable(filt));

endmodule

// File: tb/sim_pwm_leg_cond.sv
module sim_pwm_leg_cond;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_raw = 1'b0;
    logic       inhibit = 1'b0;
    logic       trip = 1'b0;
    logic [6:0] del_sel = 7'd0;
    logic [5:0] dly_sel = 6'd0;
    logic [2:0] div_sel = 3'd0;
    logic       drv_top;
    logic       drv_bot;

    always #4 clk = ~clk;

    pwm_leg_cond u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_raw(pwm_raw),
        .del_sel(del_sel),
        .dly_sel(dly_sel),
        .div_sel(div_sel),
        .inhibit(inhibit),
        .trip   (trip),
        .drv_top(drv_top),
        .drv_bot(drv_bot)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int         q_cyc[$];
    logic [1:0] q_val[$];
    string      q_tag[$];

    int   rel_cyc = 0;
    int   n_div = 1;
    int   d_del = 1;
    int   t_dly = 1;
    logic model_lvl = 1'b0;
    bit   masked = 0;
    bit   running = 0;

    logic [1:0] prev_out = 2'b00;

    // monitor: every change of the drive pair must match the next expected item
    always @(negedge clk) begin
        logic [1:0] now;
        int         ec;
        logic [1:0] ev;
        string      tg;
        now = {drv_top, drv_bot};
        if (now != prev_out) begin
            total++;
            if (q_cyc.size() == 0) begin
                bad++;
                $display("FAIL R6 unexpected change at cyc %0d: got %b expected no change", cyc, now);
            end else begin
                ec = q_cyc.pop_front();
                ev = q_val.pop_front();
                tg = q_tag.pop_front();
                if (ec != cyc || ev != now) begin
                    bad++;
                    $display("FAIL %s cyc %0d out %b, expected cyc %0d out %b", tg, cyc, now, ec, ev);
                end
            end
        end
        prev_out = now;
    end

    task automatic push(input int c, input logic [1:0] v, input string tg);
        q_cyc.push_back(c);
        q_val.push_back(v);
        q_tag.push_back(tg);
    endtask

    task automatic chk(input bit ok, input string tg, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual %0d expected %0d", tg, act, exp);
        end
    endtask

    function automatic bit is_tick(input int e);
        return (e > rel_cyc) && (((e - rel_cyc) % n_div) == 0);
    endfunction

    task automatic do_reset(input logic [6:0] ds, input logic [5:0] ys, input logic [2:0] vs);
        @(posedge clk); #1;
        if (running) push(cyc, 2'b00, "R10");
        rst_n   = 1'b0;
        pwm_raw = 1'b0;
        inhibit = 1'b0;
        trip    = 1'b0;
        del_sel = ds;
        dly_sel = ys;
        div_sel = vs;
        model_lvl = 1'b0;
        masked  = 0;
        repeat (3) @(posedge clk);
        #1;
        chk({drv_top, drv_bot} == 2'b00, "R10 outputs in reset", {drv_top, drv_bot}, 0);
        d_del = 128 - int'(ds);
        t_dly = 64 - int'(ys);
        n_div = 1 << ((vs > 3'd5) ? 5 : int'(vs));
        rst_n = 1'b1;
        rel_cyc = cyc;
        running = 1;
        push(rel_cyc + t_dly * n_div, 2'b01, "R10");
        repeat (t_dly * n_div + 4) @(posedge clk);
    endtask

    // hold pwm_raw at lvl for w clock edges and predict the drive events
    task automatic run_lvl(input logic lvl, input int w, input string tg);
        int e0;
        int seen;
        int td;
        @(posedge clk); #1;
        pwm_raw = lvl;
        e0 = cyc + 1;
        seen = 0;
        td = 0;
        for (int e = e0; e < e0 + w; e++) begin
            if (is_tick(e)) begin
                seen++;
                if (seen == d_del) td = e;
            end
        end
        if (lvl != model_lvl && seen >= d_del) begin
            if (!masked) begin
                push(td + n_div, 2'b00, tg);
                push(td + n_div + t_dly * n_div, lvl ? 2'b10 : 2'b01, tg);
            end
            model_lvl = lvl;
        end
        repeat (w - 1) @(posedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R5 watchdog expired, actual hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // D=5, T=2, N=1
        do_reset(7'd123, 6'd62, 3'd0);
        run_lvl(1'b1, 20, "R1 long high");
        run_lvl(1'b0, 20, "R1 long low");
        run_lvl(1'b1, 4,  "R1 short high deleted");
        run_lvl(1'b0, 20, "R1 low continues");
        run_lvl(1'b1, 5,  "R7 high of exactly D");
        run_lvl(1'b0, 20, "R7 low after boundary pulse");
        run_lvl(1'b1, 20, "R5 high");
        run_lvl(1'b0, 4,  "R1 short low deleted");
        run_lvl(1'b1, 20, "R1 high continues");
        run_lvl(1'b0, 20, "R5 low");
        run_lvl(1'b1, 20, "R5 high before inhibit");
        settle(5);

        // inhibit while high side on; filtered level changes underneath
        @(posedge clk); #1;
        inhibit = 1'b1;
        masked = 1;
        push(cyc, 2'b00, "R8 inhibit asserted");
        run_lvl(1'b0, 20, "R8 hidden low");
        settle(5);
        @(posedge clk); #1;
        inhibit = 1'b0;
        masked = 0;
        push(cyc, 2'b01, "R8 inhibit released");
        settle(5);

        // trip while low side on
        @(posedge clk); #1;
        trip = 1'b1;
        masked = 1;
        push(cyc, 2'b00, "R9 trip asserted");
        settle(3);
        #1;
        chk({drv_top, drv_bot} == 2'b00, "R9 outputs low under trip", {drv_top, drv_bot}, 0);
        run_lvl(1'b1, 20, "R9 hidden high");
        settle(5);
        @(posedge clk); #1;
        trip = 1'b0;
        masked = 0;
        push(cyc, 2'b10, "R9 trip released");
        settle(5);

        // all-ones codes: D=1, T=1
        do_reset(7'd127, 6'd63, 3'd0);
        run_lvl(1'b1, 3, "R2 one-tick deletion");
        run_lvl(1'b0, 3, "R4 one-tick underlap");
        run_lvl(1'b1, 3, "R2 one-tick deletion again");
        run_lvl(1'b0, 10, "R4 low");

        // all-zero codes: D=128, T=64
        do_reset(7'd0, 6'd0, 3'd0);
        run_lvl(1'b1, 127, "R2 high of D-1 deleted");
        run_lvl(1'b0, 10,  "R2 low continues");
        run_lvl(1'b1, 128, "R2 high of D passes");
        run_lvl(1'b0, 200, "R4 low with 64-tick gap");
        settle(10);

        // N=4, D=2, T=3
        do_reset(7'd126, 6'd61, 3'd2);
        run_lvl(1'b1, 40, "R3 high at divide 4");
        run_lvl(1'b0, 4,  "R3 one-sample low deleted");
        run_lvl(1'b1, 40, "R3 high continues");
        run_lvl(1'b0, 40, "R3 low at divide 4");

        // divider code above the cap: N=32
        do_reset(7'd127, 6'd63, 3'd7);
        run_lvl(1'b1, 100, "R3 clamped divide high");
        run_lvl(1'b0, 100, "R3 clamped divide low");
        settle(20);

        total++;
        if (q_cyc.size() != 0) begin
            bad++;
            $display("FAIL R5 missing drive events: actual %0d pending expected 0", q_cyc.size());
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule